// File: doc/BRIEF.md
# Command/Indication Channel Change Handler

This block serves two command/indication channels carried in the frames of a time-division serial bus. In the transmit direction it holds one code per channel in a register. It presents that code in the outgoing field of every frame until software writes a new one. In the receive direction it samples the incoming field of each channel once per frame, at the frame strobe. It keeps the last accepted code in a readable register and sets a sticky change flag when that code changes. The two flags are combined into a single interrupt line.

Channel 0 carries 4-bit codes. To filter line glitches, it accepts a new code only when the same value has been seen at two frame strobes in a row. Channel 1 has no such filter: every change is flagged at the strobe where it first appears. Its width is 4 or 6 bits, chosen by a width-select bit. In 4-bit mode the field still travels as 6 bits, with the two upper transmit bits driven to 1. In that mode the two upper receive bits take no part in change detection.

Software clears a flag by reading the matching receive register, which it marks with a one-cycle read strobe. Serializing the bus, arbitrating slot access and interpreting the codes belong to neighbouring logic.

Top module: `ci_channel_handler`

## Requirements
- R1: After reset, rx0_reg reads 4'hF, rx1_reg reads 6'h3F, tx0_code is 4'hF, tx1_code is 6'h3F, chg0, chg1 and irq are 0, and channel 1 is in 4-bit mode.
- R2: tx0_code shows the value last written through tx0_wr/tx0_wdata, and keeps it across any number of cycles and frame strobes until the next write.
- R3: A channel 0 code that differs from rx0_reg is accepted at the second of two consecutive frame strobes that carry it. On acceptance rx0_reg takes the code and chg0 becomes 1 in the cycle after that strobe.
- R4: A channel 0 code present at only one strobe, followed by either a return to rx0_reg or a different value, leaves rx0_reg and chg0 unchanged.
- R5: When the compared bits of rx1_code differ from those of rx1_reg at a frame strobe, rx1_reg takes all 6 bits of rx1_code and chg1 becomes 1 in the cycle after that same strobe.
- R6: In 4-bit mode (width bit 0), tx1_code is {2'b11, low 4 bits of the written code}, and a difference that is only in bits 5:4 of rx1_code sets no flag and leaves rx1_reg unchanged.
- R7: In 6-bit mode (width bit 1, written via wide_wr/wide_wdata), tx1_code is the whole written code and all 6 received bits are compared.
- R8: chg0 and chg1 stay set until the matching read strobe (rd0, rd1) is seen, which clears the flag in the next cycle. If a new change is detected in the same cycle as the read, the flag stays set.
- R9: irq is 1 exactly when chg0 or chg1 is 1.
- R10: Received fields are sampled only at frame strobes. Changes on rx0_code or rx1_code between strobes do not alter rx0_reg, rx1_reg, chg0 or chg1.
- R11: Receiving all-ones codes on both channels after reset raises no flag and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse at which the received fields are sampled |
| rx0_code | input | 4 | Received channel 0 field |
| rx1_code | input | 6 | Received channel 1 field |
| tx0_wr | input | 1 | Write strobe for the channel 0 transmit code |
| tx0_wdata | input | 4 | Channel 0 transmit code to write |
| tx1_wr | input | 1 | Write strobe for the channel 1 transmit code |
| tx1_wdata | input | 6 | Channel 1 transmit code to write |
| wide_wr | input | 1 | Write strobe for the channel 1 width bit |
| wide_wdata | input | 1 | Width bit: 0 selects 4-bit mode, 1 selects 6-bit mode |
| rd0 | input | 1 | Read strobe of rx0_reg; clears chg0 |
| rd1 | input | 1 | Read strobe of rx1_reg; clears chg1 |
| tx0_code | output | 4 | Channel 0 field sent in every frame |
| tx1_code | output | 6 | Channel 1 field sent in every frame |
| rx0_reg | output | 4 | Last accepted channel 0 code |
| rx1_reg | output | 6 | Last accepted channel 1 code |
| chg0 | output | 1 | Sticky channel 0 change flag |
| chg1 | output | 1 | Sticky channel 1 change flag |
| irq | output | 1 | Combined change interrupt |

## Verification
On every cycle the assertions check several properties. Both receive registers stay unchanged outside frame strobes. An update of either register is always paired with its flag. A set flag survives any cycle without a read. The interrupt follows the two flags, and the upper transmit bits of channel 1 are 1 in 4-bit mode. Some behaviour depends on the history of values across frames, and only the bench's scenarios can show it. This covers the two-strobe confirmation on channel 0, the rejection of one-frame glitches and of two different consecutive values, and the masking of the upper receive bits in 4-bit mode. It also covers the priority of a new change over a same-cycle read.

// File: rtl/ci_channel_handler.sv
module ci_channel_handler #(
  parameter int W0 = 4,
  parameter int W1 = 6,
  parameter int W1_NARROW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [W0-1:0] rx0_code,
  input  logic [W1-1:0] rx1_code,
  input  logic          tx0_wr,
  input  logic [W0-1:0] tx0_wdata,
  input  logic          tx1_wr,
  input  logic [W1-1:0] tx1_wdata,
  input  logic          wide_wr,
  input  logic          wide_wdata,
  input  logic          rd0,
  input  logic          rd1,
  output logic [W0-1:0] tx0_code,
  output logic [W1-1:0] tx1_code,
  output logic [W0-1:0] rx0_reg,
  output logic [W1-1:0] rx1_reg,
  output logic          chg0,
  output logic          chg1,
  output logic          irq
);
  localparam logic [W1-1:0] NARROW_MASK = W1'((1 << W1_NARROW) - 1);

  logic [W0-1:0] tx0_q, cand0;
  logic [W1-1:0] tx1_q, mask1;
  logic          wide_q, hit0, hit1;

  assign mask1    = wide_q ? '1 : NARROW_MASK;
  assign tx0_code = tx0_q;
  assign tx1_code = tx1_q | ~mask1;
  assign hit0     = frame_stb && (rx0_code != rx0_reg) && (rx0_code == cand0);
  assign hit1     = frame_stb && ((rx1_code & mask1) != (rx1_reg & mask1));
  assign irq      = chg0 | chg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx0_q  <= '1;
      tx1_q  <= '1;
      wide_q <= 1'b0;
    end else begin
      if (tx0_wr)  tx0_q  <= tx0_wdata;
      if (tx1_wr)  tx1_q  <= tx1_wdata;
      if (wide_wr) wide_q <= wide_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand0   <= '1;
      rx0_reg <= '1;
      chg0    <= 1'b0;
    end else begin
      if (frame_stb) cand0 <= rx0_code;
      if (hit0) rx0_reg <= rx0_code;
      chg0 <= hit0 | (chg0 & ~rd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx1_reg <= '1;
      chg1    <= 1'b0;
    end else begin
      if (hit1) rx1_reg <= rx1_code;
      chg1 <= hit1 | (chg1 & ~rd1);
    end
  end
endmodule

// File: rtl/ci_channel_handler_chk.sv
module ci_channel_handler_chk #(
  parameter int W0 = 4,
  parameter int W1 = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic          rd0,
  input logic          rd1,
  input logic          wide_q,
  input logic [W1-1:0] tx1_code,
  input logic [W0-1:0] rx0_reg,
  input logic [W1-1:0] rx1_reg,
  input logic          chg0,
  input logic          chg1,
  input logic          irq
);
  assert_rx_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(rx0_reg) && $stable(rx1_reg)));

  assert_rx0_update_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx0_reg != $past(rx0_reg)) |-> chg0);

  assert_rx1_update_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx1_reg != $past(rx1_reg)) |-> chg1);

  assert_chg0_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg0 && !rd0) |=> chg0);

  assert_chg1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg1 && !rd1) |=> chg1);

  assert_no_set_off_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> (!$rose(chg0) && !$rose(chg1)));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg0 || chg1) == irq);

  assert_narrow_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (tx1_code[W1-1:W1-2] == 2'b11));
endmodule

bind ci_channel_handler ci_channel_handler_chk #(.W0(W0), .W1(W1)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rd0(rd0), .rd1(rd1),
  .wide_q(wide_q), .tx1_code(tx1_code), .rx0_reg(rx0_reg), .rx1_reg(rx1_reg),
  .chg0(chg0), .chg1(chg1), .irq(irq)
);

// File: tb/ci_channel_handler_tb_top.sv
`timescale 1ns/1ps
module ci_channel_handler_tb_top;
  logic clk = 0, rst_n = 0, frame_stb = 0;
  logic [3:0] rx0_code = 4'hF, tx0_wdata = 0, tx0_code, rx0_reg;
  logic [5:0] rx1_code = 6'h3F, tx1_wdata = 0, tx1_code, rx1_reg;
  logic tx0_wr = 0, tx1_wr = 0, wide_wr = 0, wide_wdata = 0, rd0 = 0, rd1 = 0;
  logic chg0, chg1, irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ci_channel_handler dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [3:0] a, logic [5:0] b, logic r0 = 0, logic r1 = 0);
    @(negedge clk);
    rx0_code = a; rx1_code = b; frame_stb = 1; rd0 = r0; rd1 = r1;
    @(negedge clk);
    frame_stb = 0; rd0 = 0; rd1 = 0;
  endtask

  task automatic read(logic r0, logic r1);
    @(negedge clk); rd0 = r0; rd1 = r1;
    @(negedge clk); rd0 = 0; rd1 = 0;
  endtask

  task automatic t_reset;
    check("R1 rx0_reg", rx0_reg, 4'hF);
    check("R1 rx1_reg", rx1_reg, 6'h3F);
    check("R1 tx0_code", tx0_code, 4'hF);
    check("R1 tx1_code", tx1_code, 6'h3F);
    check("R1 flags", {irq, chg1, chg0}, 0);
  endtask

  task automatic t_idle_ones;
    strobe(4'hF, 6'h3F); strobe(4'hF, 6'h3F);
    check("R11 flags after all-ones", {irq, chg1, chg0}, 0);
  endtask

  task automatic t_ch0_accept;
    strobe(4'h5, 6'h3F);
    check("R3 first strobe no update", rx0_reg, 4'hF);
    check("R3 first strobe no flag", chg0, 0);
    strobe(4'h5, 6'h3F);
    check("R3 accepted rx0_reg", rx0_reg, 4'h5);
    check("R3 chg0 set", chg0, 1);
    check("R9 irq from chg0", irq, 1);
    repeat (3) @(negedge clk);
    check("R8 chg0 held", chg0, 1);
    read(1, 0);
    check("R8 chg0 cleared", chg0, 0);
    check("R9 irq cleared", irq, 0);
  endtask

  task automatic t_ch0_glitch;
    strobe(4'hA, 6'h3F); strobe(4'h5, 6'h3F); strobe(4'h5, 6'h3F);
    check("R4 revert keeps rx0_reg", rx0_reg, 4'h5);
    check("R4 revert no flag", chg0, 0);
    strobe(4'hA, 6'h3F); strobe(4'hC, 6'h3F);
    check("R4 two different keeps rx0_reg", rx0_reg, 4'h5);
    check("R4 two different no flag", chg0, 0);
  endtask

  task automatic t_ch1_immediate;
    strobe(4'h5, 6'h32);
    check("R5 rx1_reg at once", rx1_reg, 6'h32);
    check("R5 chg1 set", chg1, 1);
    check("R9 irq from chg1 only", {irq, chg0}, 2'b10);
    strobe(4'h5, 6'h32);
    check("R8 chg1 held over strobe", chg1, 1);
    read(0, 1);
    check("R8 chg1 cleared", chg1, 0);
  endtask

  task automatic t_narrow;
    @(negedge clk); tx1_wr = 1; tx1_wdata = 6'h05;
    @(negedge clk); tx1_wr = 0;
    check("R6 narrow tx1_code", tx1_code, 6'h35);
    strobe(4'h5, 6'h02);
    check("R6 upper-only change no flag", chg1, 0);
    check("R6 upper-only change rx1_reg", rx1_reg, 6'h32);
  endtask

  task automatic t_wide;
    @(negedge clk); wide_wr = 1; wide_wdata = 1;
    @(negedge clk); wide_wr = 0;
    check("R7 wide tx1_code", tx1_code, 6'h05);
    strobe(4'h5, 6'h02);
    check("R7 upper change flagged", chg1, 1);
    check("R7 rx1_reg", rx1_reg, 6'h02);
    read(0, 1);
  endtask

  task automatic t_priority;
    strobe(4'h9, 6'h02);
    strobe(4'h9, 6'h02, 1, 0);
    check("R8 set wins over read", chg0, 1);
    check("R3 rx0_reg 9", rx0_reg, 4'h9);
    read(1, 0);
    check("R8 cleared after read", chg0, 0);
  endtask

  task automatic t_between;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rx0_code = 4'(i); rx1_code = 6'(i + 8);
    end
    @(negedge clk);
    check("R10 rx0_reg stable", rx0_reg, 4'h9);
    check("R10 rx1_reg stable", rx1_reg, 6'h02);
    check("R10 no flags", {chg1, chg0}, 0);
  endtask

  task automatic t_tx0;
    @(negedge clk); tx0_wr = 1; tx0_wdata = 4'h6;
    @(negedge clk); tx0_wr = 0;
    strobe(4'h9, 6'h02); repeat (5) @(negedge clk);
    check("R2 tx0 held", tx0_code, 4'h6);
    @(negedge clk); tx0_wr = 1; tx0_wdata = 4'h3;
    @(negedge clk); tx0_wr = 0;
    check("R2 tx0 rewritten", tx0_code, 4'h3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_idle_ones; t_ch0_accept; t_ch0_glitch; t_ch1_immediate;
        t_narrow; t_wide; t_priority; t_between; t_tx0;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule